// File: doc/BRIEF.md
# Shared Address/Data Byte-Bus Register Slave

This block is a register slave for a narrow host link where eight general-purpose pins carry both the register index and the register value. The host first sends an index byte, with the register-select pin high, on a write strobe. It then issues any number of data reads or writes, and all of them target that index until the next index cycle. All pins are sampled on the block clock. The host holds each level for at least one clock, and a strobe counts as started on the clock edge where it is first seen low while chip select is low.

Behind the bus is a small register file. It holds an interrupt enable and status register, two bus-control bytes, low and high address bytes and data bytes for two indirect windows, two transport clock dividers, and a read-only revision byte. One control byte drives the two transport-output enables and the two tuner run lines. Interrupt events from outside latch as pending. The active-low interrupt pin reflects pending sources that are enabled. Reading the interrupt register hands the host a snapshot and clears what was pending. Each accepted strobe is acknowledged by a one-cycle low pulse on the ready pin.

Top module: `mbs_top`

## Requirements
- R1: After reset, rdy_n and irq_n are 1, bus_oe is 0, ts_en and tuner_run are 0, and every writable register and the current index read back 0x00.
- R2: A write strobe with sel_addr=1 stores bus_in as the current index. Later data reads and writes, with sel_addr=0, all use that index until the next index cycle.
- R3: The data registers at indices 0x01, 0x04, 0x05, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0C and 0x0D store all 8 bits of a data write and return them on a read.
- R4: The clock edge that accepts a read captures the addressed value. That value is driven on bus_out with bus_oe=1 while cs_n and rd_n stay low. bus_oe is 0 at every other time.
- R5: rdy_n is 0 for exactly the one cycle after the edge that accepts a read or write strobe, and 1 otherwise.
- R6: A 1 on irq_evt[i] at a clock edge makes source i pending. irq_n is 0 while any source is both pending and enabled.
- R7: A read of index 0x00 returns {0, en1, 0, pend1, 0, en0, 0, pend0} (bit 7 first) as it stood before the accepting edge, and it clears both pending flags at that edge. An event at that same edge stays pending.
- R8: A data write to index 0x00 stores only bit 2 (source 0 enable) and bit 6 (source 1 enable). Writing 0x44 enables both sources.
- R9: ts_en equals bits 5:4 and tuner_run equals bits 3:2 of the register at index 0x01, and they change only after a write.
- R10: Index 0x0F reads the REV parameter and ignores writes. Writes to unmapped indices are ignored, and reads of them return 0x00.
- R11: Strobes seen while cs_n is 1 are ignored: no register changes and no rdy_n pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sel_addr | input | 1 | High on a write: the byte is an index |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_in | input | 8 | Byte from the host |
| bus_out | output | 8 | Byte to the host |
| bus_oe | output | 1 | Drive enable for bus_out |
| rdy_n | output | 1 | One-cycle acknowledge, active low |
| irq_evt | input | NSRC | Interrupt event pulses |
| irq_n | output | 1 | Interrupt request, active low |
| ts_en | output | 2 | Transport output enables |
| tuner_run | output | 2 | Tuner run lines, active high |

## Verification
The critical collision is an interrupt event landing on the same clock edge that accepts a read of the interrupt register. At that edge the clear and the new set compete. The bench raises an event on source 1 in the very cycle its read strobe falls. It then expects the captured byte to omit the new event, and it expects irq_n to stay low afterwards until a second read clears it. A behavioural reference model, updated on every clock, judges both outcomes together with the ready pulse and the bus drive.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int DW   = 8;
    localparam int NSRC = 2;

    localparam logic [DW-1:0] IX_IRQ  = 8'h00;
    localparam logic [DW-1:0] IX_CTL2 = 8'h01;
    localparam logic [DW-1:0] IX_CAL  = 8'h04;
    localparam logic [DW-1:0] IX_CAH  = 8'h05;
    localparam logic [DW-1:0] IX_CDAT = 8'h06;
    localparam logic [DW-1:0] IX_CTL  = 8'h07;
    localparam logic [DW-1:0] IX_FAL  = 8'h08;
    localparam logic [DW-1:0] IX_FAH  = 8'h09;
    localparam logic [DW-1:0] IX_FDAT = 8'h0A;
    localparam logic [DW-1:0] IX_DIVA = 8'h0C;
    localparam logic [DW-1:0] IX_DIVB = 8'h0D;
    localparam logic [DW-1:0] IX_REV  = 8'h0F;

    // per-source field stride inside the interrupt register
    localparam int IRQ_STRIDE = 4;
    localparam int IRQ_EN_OFS = 2;

    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
        logic ack;
        logic rd_act;
    } strobe_t;

    typedef struct packed {
        logic [DW-1:0] index;
        logic [DW-1:0] ctl2;
        logic [DW-1:0] cal;
        logic [DW-1:0] cah;
        logic [DW-1:0] cdat;
        logic [DW-1:0] ctl;
        logic [DW-1:0] fal;
        logic [DW-1:0] fah;
        logic [DW-1:0] fdat;
        logic [DW-1:0] diva;
        logic [DW-1:0] divb;
        logic [DW-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/mbs_strobe.sv
module mbs_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_go,
    output logic rd_go,
    output logic ack,
    output logic rd_act
);
    import mbs_pkg::*;

    strobe_t st_d, st_q;

    always_comb begin
        wr_go = ~cs_n & ~wr_n & st_q.wr_prev;
        rd_go = ~cs_n & ~rd_n & st_q.rd_prev;
        st_d  = st_q;
        st_d.wr_prev = wr_n;
        st_d.rd_prev = rd_n;
        st_d.ack     = wr_go | rd_go;
        if (rd_go)
            st_d.rd_act = 1'b1;
        else if (rd_n)
            st_d.rd_act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_prev <= 1'b1;
            st_q.rd_prev <= 1'b1;
            st_q.ack     <= 1'b0;
            st_q.rd_act  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack    = st_q.ack;
    assign rd_act = st_q.rd_act;
endmodule

// File: rtl/mbs_irq.sv
module mbs_irq #(
    parameter int NSRC = mbs_pkg::NSRC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        evt,
    input  logic                   en_we,
    input  logic [NSRC-1:0]        en_wdata,
    input  logic                   clr,
    output logic [mbs_pkg::DW-1:0] status,
    output logic                   irq_n
);
    import mbs_pkg::*;

    logic [NSRC-1:0] pend_d, pend_q;
    logic [NSRC-1:0] en_d,   en_q;

    always_comb begin
        pend_d = (clr ? '0 : pend_q) | evt;
        en_d   = en_we ? en_wdata : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
        end
    end

    always_comb begin
        status = '0;
        for (int i = 0; i < NSRC; i++) begin
            status[IRQ_STRIDE*i]              = pend_q[i];
            status[IRQ_STRIDE*i + IRQ_EN_OFS] = en_q[i];
        end
    end

    assign irq_n = ~|(pend_q & en_q);
endmodule

// File: rtl/mbs_regs.sv
module mbs_regs #(
    parameter logic [7:0] REV  = 8'hA7,
    parameter int         NSRC = mbs_pkg::NSRC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_go,
    input  logic                   rd_go,
    input  logic                   sel_addr,
    input  logic [mbs_pkg::DW-1:0] din,
    input  logic [mbs_pkg::DW-1:0] irq_status,
    output logic                   irq_en_we,
    output logic [NSRC-1:0]        irq_en_wdata,
    output logic                   irq_clr,
    output logic [mbs_pkg::DW-1:0] rdata,
    output logic [1:0]             ts_en,
    output logic [1:0]             tuner_run
);
    import mbs_pkg::*;

    regs_t         r_d, r_q;
    logic [DW-1:0] rmux;
    logic          data_wr;

    always_comb begin
        case (r_q.index)
            IX_IRQ:  rmux = irq_status;
            IX_CTL2: rmux = r_q.ctl2;
            IX_CAL:  rmux = r_q.cal;
            IX_CAH:  rmux = r_q.cah;
            IX_CDAT: rmux = r_q.cdat;
            IX_CTL:  rmux = r_q.ctl;
            IX_FAL:  rmux = r_q.fal;
            IX_FAH:  rmux = r_q.fah;
            IX_FDAT: rmux = r_q.fdat;
            IX_DIVA: rmux = r_q.diva;
            IX_DIVB: rmux = r_q.divb;
            IX_REV:  rmux = REV;
            default: rmux = '0;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        data_wr = wr_go & ~sel_addr;
        if (wr_go && sel_addr)
            r_d.index = din;
        if (data_wr) begin
            case (r_q.index)
                IX_CTL2: r_d.ctl2 = din;
                IX_CAL:  r_d.cal  = din;
                IX_CAH:  r_d.cah  = din;
                IX_CDAT: r_d.cdat = din;
                IX_CTL:  r_d.ctl  = din;
                IX_FAL:  r_d.fal  = din;
                IX_FAH:  r_d.fah  = din;
                IX_FDAT: r_d.fdat = din;
                IX_DIVA: r_d.diva = din;
                IX_DIVB: r_d.divb = din;
                default: ;
            endcase
        end
        if (rd_go)
            r_d.rdata = rmux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_en
            assign irq_en_wdata[i] = din[IRQ_STRIDE*i + IRQ_EN_OFS];
        end
    endgenerate

    assign irq_en_we = data_wr && (r_q.index == IX_IRQ);
    assign irq_clr   = rd_go && (r_q.index == IX_IRQ);
    assign rdata     = r_q.rdata;
    assign ts_en     = r_q.ctl2[5:4];
    assign tuner_run = r_q.ctl2[3:2];
endmodule

// File: rtl/mbs_top.sv
module mbs_top #(
    parameter logic [7:0] REV  = 8'hA7,
    parameter int         NSRC = mbs_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sel_addr,
    input  logic            wr_n,
    input  logic            rd_n,
    input  logic [7:0]      bus_in,
    output logic [7:0]      bus_out,
    output logic            bus_oe,
    output logic            rdy_n,
    input  logic [NSRC-1:0] irq_evt,
    output logic            irq_n,
    output logic [1:0]      ts_en,
    output logic [1:0]      tuner_run
);
    logic            wr_go, rd_go, ack, rd_act;
    logic            en_we, clr;
    logic [NSRC-1:0] en_wdata;
    logic [7:0]      status;

    mbs_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .wr_go(wr_go), .rd_go(rd_go), .ack(ack), .rd_act(rd_act)
    );

    mbs_irq #(.NSRC(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt), .en_we(en_we),
        .en_wdata(en_wdata), .clr(clr), .status(status), .irq_n(irq_n)
    );

    mbs_regs #(.REV(REV), .NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
        .sel_addr(sel_addr), .din(bus_in), .irq_status(status),
        .irq_en_we(en_we), .irq_en_wdata(en_wdata), .irq_clr(clr),
        .rdata(bus_out), .ts_en(ts_en), .tuner_run(tuner_run)
    );

    assign bus_oe = rd_act & ~rd_n & ~cs_n;
    assign rdy_n  = ~ack;
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wr_n,
    input logic       rd_n,
    input logic       rdy_n,
    input logic       bus_oe,
    input logic       irq_n,
    input logic [1:0] ts_en
);
    assert_ack_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |=> rdy_n);

    assert_ack_needs_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> $past(!cs_n));

    assert_drive_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!rd_n && !cs_n));

    assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(!cs_n && (!rd_n || !wr_n)));

    assert_ts_change_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ts_en) |-> $past(!cs_n && !wr_n));
endmodule

bind mbs_top mbs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .rdy_n(rdy_n), .bus_oe(bus_oe), .irq_n(irq_n), .ts_en(ts_en)
);

// File: tb/sim_mbs_top.sv
`timescale 1ns/1ps
module sim_mbs_top;
    localparam logic [7:0] REV_V = 8'hA7;

    logic       clk = 0, rst_n = 0;
    logic       cs_n = 1, sel_addr = 0, wr_n = 1, rd_n = 1;
    logic [7:0] bus_in = 0;
    logic [1:0] irq_evt = 0;
    logic [7:0] bus_out;
    logic       bus_oe, rdy_n, irq_n;
    logic [1:0] ts_en, tuner_run;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbs_top #(.REV(REV_V), .NSRC(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel_addr(sel_addr),
        .wr_n(wr_n), .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .rdy_n(rdy_n), .irq_evt(irq_evt), .irq_n(irq_n),
        .ts_en(ts_en), .tuner_run(tuner_run)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    logic [7:0] m_reg [0:15];
    logic [7:0] m_idx, m_rdata;
    logic [1:0] m_en, m_pend;
    logic m_wprev, m_rprev, m_ack, m_act;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return {1'b0, m_en[1], 1'b0, m_pend[1], 1'b0, m_en[0], 1'b0, m_pend[0]};
        if (a == 8'h0F) return REV_V;
        if (a == 8'h01 || (a >= 8'h04 && a <= 8'h0A) || a == 8'h0C || a == 8'h0D)
            return m_reg[a[3:0]];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_reg[i] = 0;
            m_idx = 0; m_rdata = 0; m_en = 0; m_pend = 0;
            m_wprev = 1; m_rprev = 1; m_ack = 0; m_act = 0;
        end else begin
            automatic bit wgo = !cs_n && !wr_n && m_wprev;
            automatic bit rgo = !cs_n && !rd_n && m_rprev;
            automatic logic [7:0] a = m_idx;
            automatic bit clr = 0;
            m_ack = wgo || rgo;
            if (rgo) begin
                m_rdata = m_read(a);
                clr = (a == 8'h00);
            end
            if (wgo) begin
                if (sel_addr) m_idx = bus_in;
                else if (a == 8'h00) m_en = {bus_in[6], bus_in[2]};
                else if (m_read(a) == m_reg[a[3:0]] && a != 8'h0F && a < 8'h10 &&
                         (a == 8'h01 || (a >= 8'h04 && a <= 8'h0A) || a == 8'h0C || a == 8'h0D))
                    m_reg[a[3:0]] = bus_in;
            end
            if (clr) m_pend = 0;
            m_pend = m_pend | irq_evt;
            if (rgo) m_act = 1; else if (rd_n) m_act = 0;
            m_wprev = wr_n; m_rprev = rd_n;
        end
        #2;
        if (rst_n) begin
            chk("R5 rdy_n", {7'b0, rdy_n}, {7'b0, !m_ack});
            chk("R6 irq_n", {7'b0, irq_n}, {7'b0, !(|(m_pend & m_en))});
            chk("R4 bus_oe", {7'b0, bus_oe}, {7'b0, m_act && !cs_n && !rd_n});
            if (bus_oe) chk("R3 bus_out", bus_out, m_rdata);
            chk("R9 ts_en", {6'b0, ts_en}, {6'b0, m_reg[1][5:4]});
            chk("R9 tuner_run", {6'b0, tuner_run}, {6'b0, m_reg[1][3:2]});
        end
    end

    task automatic do_write(input logic s, input logic [7:0] v);
        @(negedge clk); cs_n = 0; sel_addr = s; bus_in = v; wr_n = 0;
        @(negedge clk); wr_n = 1; cs_n = 1; sel_addr = 0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] ev, output logic [7:0] d);
        @(negedge clk); cs_n = 0; rd_n = 0; irq_evt = ev;
        @(negedge clk); irq_evt = 0; d = bus_out;
        rd_n = 1; cs_n = 1;
        @(negedge clk);
    endtask

    task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
        do_write(1, a);
        do_read(2'b00, d);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        chk("R1 rdy_n", {7'b0, rdy_n}, 8'h01);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        chk("R1 outs", {4'b0, ts_en, tuner_run}, 8'h00);
        rd_at(8'h06, d); chk("R1 reg reset", d, 8'h00);

        // R2/R9: index then repeated data cycles
        do_write(1, 8'h01);
        do_write(0, 8'h3C);
        chk("R9 ts_en", {6'b0, ts_en}, 8'h03);
        chk("R9 tuner_run", {6'b0, tuner_run}, 8'h03);
        do_read(0, d); chk("R2 readback", d, 8'h3C);
        do_write(0, 8'h14);
        do_read(0, d); chk("R2 index kept", d, 8'h14);
        chk("R9 ts split", {4'b0, ts_en, tuner_run}, 8'h05);

        // R3 every data register
        for (int i = 0; i < 16; i++) begin
            if (i == 1 || (i >= 4 && i <= 10) || i == 12 || i == 13) begin
                do_write(1, 8'(i));
                do_write(0, 8'(i) ^ 8'h5A);
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (i == 1 || (i >= 4 && i <= 10) || i == 12 || i == 13) begin
                rd_at(8'(i), d); chk("R3 data reg", d, 8'(i) ^ 8'h5A);
            end
        end

        // R10 revision and unmapped
        rd_at(8'h0F, d); chk("R10 rev", d, REV_V);
        do_write(0, 8'hFF);
        do_read(0, d); chk("R10 rev write ignored", d, REV_V);
        do_write(1, 8'h03); do_write(0, 8'h77);
        do_read(0, d); chk("R10 unmapped", d, 8'h00);
        rd_at(8'h20, d); chk("R10 high unmapped", d, 8'h00);

        // R11 strobe with chip select high
        do_write(1, 8'h0C);
        @(negedge clk); bus_in = 8'h99; wr_n = 0;
        @(negedge clk); chk("R11 no ack", {7'b0, rdy_n}, 8'h01); wr_n = 1;
        @(negedge clk);
        do_read(0, d); chk("R11 reg kept", d, 8'h0C ^ 8'h5A);

        // R6/R7/R8 interrupt
        @(negedge clk); irq_evt = 2'b01; @(negedge clk); irq_evt = 0;
        chk("R6 masked", {7'b0, irq_n}, 8'h01);
        do_write(1, 8'h00); do_write(0, 8'h44);
        chk("R8 enable 0x44", {7'b0, irq_n}, 8'h00);
        do_read(0, d); chk("R7 snapshot", d, 8'h45);
        chk("R7 cleared", {7'b0, irq_n}, 8'h01);
        do_write(0, 8'hFF);
        do_read(0, d); chk("R8 only enables", d, 8'h44);
        do_read(2'b10, d); chk("R7 same-cycle snapshot", d, 8'h44);
        chk("R7 event survives clear", {7'b0, irq_n}, 8'h00);
        do_read(0, d); chk("R7 second read", d, 8'h54);
        chk("R7 now clear", {7'b0, irq_n}, 8'h01);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule